// File: doc/BRIEF.md
# Floating-Point Compare and Flag Unit

This block compares two IEEE-754 operands of the same format (half, single or double precision) and returns the outcome in one of two forms. A scalar compare gives a four-bit condition nibble. A lane compare evaluates one predicate and returns a lane-wide mask of all ones or all zeros. Both forms also report an invalid-operation exception whose rules depend on whether the compare is quiet or signalling.

Operands arrive right-aligned on 64-bit buses. Bits above the selected format's width are ignored. A valid strobe loads one compare, and the result, the mask and the exception bit are registered together. They appear one clock later and hold until the next strobe.

Top module: `fcmp_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `res_valid` is high for the following cycle, and `flags`, `mask` and `invalid` reflect that compare. Without a strobe, `res_valid` is low and the other outputs hold their values.
- R2: `fmt` selects the width: 0 is half (bits 15:0), 1 is single (bits 31:0), and 2 or 3 is double (bits 63:0). Operand bits above the selected width have no effect.
- R3: `flags` is {N,Z,C,V} from bit 3 down to bit 0. Less-than gives 4'b1000, equal gives 4'b0110 and greater-than gives 4'b0010. Negative values order below positive ones, and two negative values order by reversed magnitude.
- R4: If either operand is a NaN (exponent all ones, fraction non-zero), the result is unordered and `flags` is 4'b0011.
- R5: Positive zero and negative zero compare equal.
- R6: Quiet operations are `op`=0 (scalar quiet) and `op`=2 (lane equal). They set `invalid` only when an operand is a signalling NaN, which is a NaN whose fraction MSB is 0.
- R7: Signalling operations are `op`=1 (scalar signalling), `op`=3..6 (lane predicates) and `op`=7 (behaves as `op`=1). They set `invalid` for any NaN operand.
- R8: In lane operations (`op`=2..6), a true predicate sets `mask` to all ones in the low lane-width bits (16, 32 or 64) and zero above them. A false predicate sets `mask` to zero. In scalar operations `mask` is zero.
- R9: The lane predicates are equal (`op`=2), greater-or-equal (`op`=3) and greater-than (`op`=4), each of A against B. Every predicate is false when the result is unordered.
- R10: The absolute predicates, greater-or-equal (`op`=5) and greater-than (`op`=6), clear both sign bits before comparing.
- R11: After reset, `res_valid`, `flags`, `mask` and `invalid` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Loads one compare |
| fmt | input | 2 | Operand format select |
| op | input | 3 | Operation select |
| opa | input | 64 | Operand A, right-aligned |
| opb | input | 64 | Operand B, right-aligned |
| res_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| flags | output | 4 | N,Z,C,V condition nibble |
| mask | output | 64 | Lane predicate mask |
| invalid | output | 1 | Invalid-operation exception |

## Verification
Ordered pairs are tried with mixed signs and with both operands negative, which shows whether sign handling and reversed magnitude ordering are right. Signed zeros are tried to show that zero is special-cased rather than compared bit by bit. Quiet and signalling NaNs are driven through both the quiet and the signalling operations, which separates the two exception rules. Lane predicates are checked on equal and unequal pairs in every format, with and without the absolute variant, so that off-by-one predicates, wrong mask widths and dropped sign clearing are each caught. Garbage in the upper operand bits shows whether the format select truly isolates the operand fields.

// File: rtl/fcmp_pkg.sv
// Package: shared types and constants for the floating-point compare unit.
// Assumes both operands share one format; widths come from format index.
package fcmp_pkg;

    localparam int OPW = 64;
    localparam int MAGW = OPW - 1;
    localparam int NFMT = 3;

    typedef enum logic [1:0] {
        FMT_HALF = 2'd0,
        FMT_SING = 2'd1,
        FMT_DBL  = 2'd2,
        FMT_DBLX = 2'd3
    } fmt_e;

    typedef enum logic [2:0] {
        OP_SCMP_Q = 3'd0,
        OP_SCMP_S = 3'd1,
        OP_L_EQ   = 3'd2,
        OP_L_GE   = 3'd3,
        OP_L_GT   = 3'd4,
        OP_L_AGE  = 3'd5,
        OP_L_AGT  = 3'd6,
        OP_SCMP_X = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic            sign;
        logic            nan;
        logic            snan;
        logic            zero;
        logic [MAGW-1:0] mag;
    } opnd_t;

    localparam logic [3:0] NZCV_LT = 4'b1000;
    localparam logic [3:0] NZCV_EQ = 4'b0110;
    localparam logic [3:0] NZCV_GT = 4'b0010;
    localparam logic [3:0] NZCV_UN = 4'b0011;

    // exponent width for format index 0 (half), 1 (single), 2 (double)
    function automatic int exp_w(input int f);
        return (f == 0) ? 5 : (f == 1) ? 8 : 11;
    endfunction

    // fraction width for the same format indices
    function automatic int man_w(input int f);
        return (f == 0) ? 10 : (f == 1) ? 23 : 52;
    endfunction

    // condition nibble for a relation
    function automatic logic [3:0] nzcv_of(input rel_e r);
        case (r)
            REL_LT:  return NZCV_LT;
            REL_EQ:  return NZCV_EQ;
            REL_GT:  return NZCV_GT;
            default: return NZCV_UN;
        endcase
    endfunction

    // all-ones fill of the lane width for a format
    function automatic logic [OPW-1:0] lane_fill(input fmt_e f);
        case (f)
            FMT_HALF: return {{(OPW-16){1'b0}}, 16'hFFFF};
            FMT_SING: return {{(OPW-32){1'b0}}, 32'hFFFF_FFFF};
            default:  return {OPW{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/fcmp_unpack.sv
// Module: splits one operand into sign, NaN class, zero flag and magnitude.
// Assumes the operand is right-aligned; bits above the format are ignored.
// The magnitude is the encoding without its sign bit, which orders like the value.
module fcmp_unpack
    import fcmp_pkg::*;
(
    input  logic [OPW-1:0] raw_i,
    input  fmt_e           fmt_i,
    input  logic           clr_sign_i,
    output opnd_t          opnd_o
);

    opnd_t cand [NFMT];

    // one decoder per supported format
    for (genvar g = 0; g < NFMT; g++) begin : g_fmt
        localparam int EW = exp_w(g);
        localparam int MW = man_w(g);
        localparam int TW = 1 + EW + MW;

        logic [TW-1:0] fld;
        logic          exp_ones;
        logic          man_nz;

        // field extraction and classification for this format
        always_comb begin
            fld            = raw_i[TW-1:0];
            exp_ones       = &fld[TW-2:MW];
            man_nz         = |fld[MW-1:0];
            cand[g].sign   = fld[TW-1] & ~clr_sign_i;
            cand[g].nan    = exp_ones & man_nz;
            cand[g].snan   = exp_ones & man_nz & ~fld[MW-1];
            cand[g].zero   = ~|fld[TW-2:0];
            cand[g].mag    = MAGW'(fld[TW-2:0]);
        end
    end

    // choose the decoder selected by the format field
    always_comb begin
        case (fmt_i)
            FMT_HALF: opnd_o = cand[0];
            FMT_SING: opnd_o = cand[1];
            default:  opnd_o = cand[2];
        endcase
    end

endmodule

// File: rtl/fcmp_relate.sv
// Module: orders two unpacked operands into less, equal, greater or unordered.
// Assumes both operands come from the same format decoder.
module fcmp_relate
    import fcmp_pkg::*;
(
    input  opnd_t a_i,
    input  opnd_t b_i,
    output rel_e  rel_o
);

    logic mag_lt;
    logic mag_eq;

    // unsigned magnitude comparison
    always_comb begin
        mag_lt = a_i.mag < b_i.mag;
        mag_eq = a_i.mag == b_i.mag;
    end

    // relation selection: NaN first, then signed zeros, then sign, then magnitude
    always_comb begin
        if (a_i.nan || b_i.nan) begin
            rel_o = REL_UN;
        end else if (a_i.zero && b_i.zero) begin
            rel_o = REL_EQ;
        end else if (a_i.sign != b_i.sign) begin
            rel_o = a_i.sign ? REL_LT : REL_GT;
        end else if (mag_eq) begin
            rel_o = REL_EQ;
        end else if (a_i.sign) begin
            rel_o = mag_lt ? REL_GT : REL_LT;
        end else begin
            rel_o = mag_lt ? REL_LT : REL_GT;
        end
    end

endmodule

// File: rtl/fcmp_unit.sv
// Module: top of the compare unit. It decodes the operation, compares the
// operands and registers the flags, mask and exception one cycle after a strobe.
// Assumes fmt and op are stable with in_valid; outputs hold between strobes.
module fcmp_unit
    import fcmp_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [1:0]     fmt,
    input  logic [2:0]     op,
    input  logic [63:0]    opa,
    input  logic [63:0]    opb,
    output logic           res_valid,
    output logic [3:0]     flags,
    output logic [63:0]    mask,
    output logic           invalid
);

    fmt_e         fmt_s;
    op_e          op_s;
    logic         is_lane;
    logic         is_abs;
    logic         is_quiet;
    opnd_t        ua;
    opnd_t        ub;
    rel_e         rel;
    logic         pred;
    logic [3:0]   flags_d;
    logic [63:0]  mask_d;
    logic         inv_d;

    // operation decode
    always_comb begin
        fmt_s    = fmt_e'(fmt);
        op_s     = op_e'(op);
        is_lane  = (op_s == OP_L_EQ) || (op_s == OP_L_GE) || (op_s == OP_L_GT) ||
                   (op_s == OP_L_AGE) || (op_s == OP_L_AGT);
        is_abs   = (op_s == OP_L_AGE) || (op_s == OP_L_AGT);
        is_quiet = (op_s == OP_SCMP_Q) || (op_s == OP_L_EQ);
    end

    fcmp_unpack u_unp_a (
        .raw_i      (opa),
        .fmt_i      (fmt_s),
        .clr_sign_i (is_abs),
        .opnd_o     (ua)
    );

    fcmp_unpack u_unp_b (
        .raw_i      (opb),
        .fmt_i      (fmt_s),
        .clr_sign_i (is_abs),
        .opnd_o     (ub)
    );

    fcmp_relate u_rel (
        .a_i   (ua),
        .b_i   (ub),
        .rel_o (rel)
    );

    // predicate evaluation for lane operations
    always_comb begin
        case (op_s)
            OP_L_EQ:           pred = (rel == REL_EQ);
            OP_L_GE, OP_L_AGE: pred = (rel == REL_EQ) || (rel == REL_GT);
            OP_L_GT, OP_L_AGT: pred = (rel == REL_GT);
            default:           pred = 1'b0;
        endcase
    end

    // next-state result, mask and exception
    always_comb begin
        flags_d = nzcv_of(rel);
        mask_d  = (is_lane && pred) ? lane_fill(fmt_s) : '0;
        inv_d   = is_quiet ? (ua.snan | ub.snan) : (ua.nan | ub.nan);
    end

    // output register, loaded on the input strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            flags     <= '0;
            mask      <= '0;
            invalid   <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                flags   <= flags_d;
                mask    <= mask_d;
                invalid <= inv_d;
            end
        end
    end

    a_r1_strobe_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(flags) && $stable(mask) && $stable(invalid)));

    a_r3_flag_code: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flags == NZCV_LT || flags == NZCV_EQ ||
                       flags == NZCV_GT || flags == NZCV_UN));

    a_r9_unordered_false: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && flags == NZCV_UN) |-> (mask == '0));

    a_r6_invalid_needs_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && flags != NZCV_UN) |-> !invalid);

    a_r8_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones(mask) == 0 || $countones(mask) == 16 ||
                       $countones(mask) == 32 || $countones(mask) == 64));

endmodule

// File: tb/fcmp_unit_tb_top.sv
// Directed bench for the compare unit; each task drives and checks one scenario.
module fcmp_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [2:0]  op = 3'd0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        res_valid;
    logic [3:0]  flags;
    logic [63:0] mask;
    logic        invalid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fcmp_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .fmt       (fmt),
        .op        (op),
        .opa       (opa),
        .opb       (opb),
        .res_valid (res_valid),
        .flags     (flags),
        .mask      (mask),
        .invalid   (invalid)
    );

    localparam logic [3:0] LT = 4'b1000, EQ = 4'b0110, GT = 4'b0010, UN = 4'b0011;
    localparam logic [63:0] M16 = 64'hFFFF, M32 = 64'hFFFF_FFFF, M64 = '1;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one strobe; afterwards the registered result is visible at the next negedge
    task automatic drive(input logic [1:0] f, input logic [2:0] o,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        fmt = f; op = o; opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 res_valid", 64'(res_valid), 0);
        chk("R11 flags", 64'(flags), 0);
        chk("R11 mask", mask, 0);
        chk("R11 invalid", 64'(invalid), 0);
    endtask

    task automatic t_order;
        drive(2'd1, 3'd0, 64'h3F80_0000, 64'h4000_0000);
        chk("R3 single 1<2", 64'(flags), 64'(LT));
        drive(2'd1, 3'd0, 64'h4000_0000, 64'h3F80_0000);
        chk("R3 single 2>1", 64'(flags), 64'(GT));
        drive(2'd1, 3'd1, 64'h3F80_0000, 64'h3F80_0000);
        chk("R3 single 1=1", 64'(flags), 64'(EQ));
        drive(2'd0, 3'd0, 64'hBC00, 64'h3C00);
        chk("R3 half -1<1", 64'(flags), 64'(LT));
        drive(2'd2, 3'd0, 64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000);
        chk("R3 double -1>-2", 64'(flags), 64'(GT));
        chk("R8 scalar mask zero", mask, 0);
    endtask

    task automatic t_latency;
        drive(2'd1, 3'd0, 64'h4000_0000, 64'h3F80_0000);
        chk("R1 valid after strobe", 64'(res_valid), 1);
        @(negedge clk);
        opa = 64'h0; opb = 64'h3F80_0000;
        @(negedge clk);
        chk("R1 valid drops", 64'(res_valid), 0);
        chk("R1 flags held", 64'(flags), 64'(GT));
    endtask

    task automatic t_format;
        drive(2'd0, 3'd0, 64'hFFFF_FFFF_FFFF_3C00, 64'h1234_5678_0000_4000);
        chk("R2 half ignores upper", 64'(flags), 64'(LT));
        drive(2'd1, 3'd0, 64'h8000_0000_3F80_0000, 64'h7FF8_0000_4000_0000);
        chk("R2 single ignores upper", 64'(flags), 64'(LT));
        chk("R2 single no nan", 64'(invalid), 0);
        drive(2'd3, 3'd0, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000);
        chk("R2 fmt3 as double", 64'(flags), 64'(GT));
    endtask

    task automatic t_zero;
        drive(2'd0, 3'd0, 64'h0000, 64'h8000);
        chk("R5 half +0=-0", 64'(flags), 64'(EQ));
        drive(2'd2, 3'd2, 64'h8000_0000_0000_0000, 64'h0);
        chk("R5 double -0 eq lane", mask, M64);
    endtask

    task automatic t_nan;
        drive(2'd0, 3'd0, 64'h7E00, 64'h3C00);
        chk("R4 qnan unordered", 64'(flags), 64'(UN));
        chk("R6 quiet qnan no invalid", 64'(invalid), 0);
        drive(2'd1, 3'd0, 64'h3F80_0000, 64'h7F80_0001);
        chk("R6 quiet snan invalid", 64'(invalid), 1);
        chk("R4 snan unordered", 64'(flags), 64'(UN));
        drive(2'd2, 3'd1, 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000);
        chk("R7 signalling qnan invalid", 64'(invalid), 1);
        drive(2'd1, 3'd2, 64'h7FC0_0000, 64'h7FC0_0000);
        chk("R6 lane eq qnan no invalid", 64'(invalid), 0);
        chk("R9 lane eq unordered false", mask, 0);
        drive(2'd2, 3'd4, 64'h4000_0000_0000_0000, 64'h7FF8_0000_0000_0000);
        chk("R7 lane gt qnan invalid", 64'(invalid), 1);
        chk("R9 lane gt unordered false", mask, 0);
        drive(2'd0, 3'd7, 64'h7E00, 64'h3C00);
        chk("R7 op7 qnan invalid", 64'(invalid), 1);
    endtask

    task automatic t_lane;
        drive(2'd1, 3'd3, 64'h4000_0000, 64'h3F80_0000);
        chk("R8 single ge width", mask, M32);
        drive(2'd1, 3'd3, 64'h3F80_0000, 64'h3F80_0000);
        chk("R9 ge on equal", mask, M32);
        drive(2'd1, 3'd4, 64'h3F80_0000, 64'h3F80_0000);
        chk("R9 gt on equal", mask, 0);
        drive(2'd0, 3'd2, 64'h3C00, 64'h3C00);
        chk("R8 half eq width", mask, M16);
        drive(2'd0, 3'd2, 64'h3C00, 64'h4000);
        chk("R9 eq on unequal", mask, 0);
        drive(2'd2, 3'd4, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000);
        chk("R8 double gt width", mask, M64);
        drive(2'd1, 3'd3, 64'h3F80_0000, 64'h4000_0000);
        chk("R9 ge on less", mask, 0);
    endtask

    task automatic t_abs;
        drive(2'd1, 3'd6, 64'hC000_0000, 64'h3F80_0000);
        chk("R10 abs gt -2 vs 1", mask, M32);
        drive(2'd1, 3'd4, 64'hC000_0000, 64'h3F80_0000);
        chk("R10 plain gt -2 vs 1", mask, 0);
        drive(2'd0, 3'd5, 64'hBC00, 64'h3C00);
        chk("R10 abs ge -1 vs 1", mask, M16);
        drive(2'd0, 3'd6, 64'hBC00, 64'h3C00);
        chk("R10 abs gt -1 vs 1", mask, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_latency();
        t_format();
        t_zero();
        t_nan();
        t_lane();
        t_abs();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule